// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresh Unit

This unit sits next to the bank state logic of a DRAM memory controller and guards against disturbance errors, where a row that is opened and closed over and over causes charge to leak from the rows beside it. Every time the controller closes a row, the unit reports the event together with the closed row address. The unit then draws a 16-bit pseudo-random value and compares it with a programmable threshold. If the draw falls below the threshold, the unit queues one extra refresh of a row adjacent to the closed one. That refresh goes to the command scheduler as an activate followed by a precharge of the neighbour row.

The threshold encodes the refresh probability as threshold/65536. A setting of 328 gives p ≈ 0.005, which is five times a 0.001 baseline and covers up to ten neighbouring rows. When successive hits land on interior rows, the refresh alternates between the row below and the row above. At the two ends of the address range the only existing neighbour is chosen. The queue holds a single refresh. A hit that arrives while that slot is occupied is dropped and counted. Free-running counters of close events and queued refreshes let the hit rate be measured.

The control is a three-state machine:
- ST_IDLE: nothing pending.
- ST_ACT: an activate request is offered.
- ST_PRE: a precharge request is offered.

Its transitions are:
- IDLE→ACT on a hit accepted into the empty slot.
- ACT→PRE when the scheduler takes the activate.
- PRE→IDLE when the scheduler takes the precharge.

Top module: `para_refresh_unit`

## Requirements
- R1: After synchronous reset: `ref_valid` is 0, all three counters read 0, the random source holds 0xACE1, and the next interior hit goes to row R-1.
- R2: The random source is a 16-bit shift register that shifts left by one on each close event and only then. Bit 0 receives bit15 XOR bit13 XOR bit12 XOR bit10. A close is a hit when the value held before that shift is less than `threshold`, compared as unsigned.
- R3: A close that is not a hit produces no request. With `threshold` = 0, `ref_valid` never rises.
- R4: In the cycle after a hit is accepted, `ref_valid`=1 with `ref_cmd`=0 (activate) and `ref_row` set to the neighbour. After that request is accepted (`ref_valid` and `ref_ready` both high at a clock edge), the next cycle offers `ref_cmd`=1 (precharge) with the same row. After that request is accepted, `ref_valid` returns to 0. While `ref_ready` is low, the offered command and row stay unchanged.
- R5: Accepted hits on interior rows alternate between R-1 and R+1, starting with R-1 after reset.
- R6: A hit on row 0 refreshes row 1, and a hit on the highest row refreshes the row below it. Neither case changes which side the next interior hit uses.
- R7: A hit arriving while a request is pending (state not idle) is dropped. It increments `drop_count`, which saturates at its maximum, and it leaves the pending request and the alternation side unchanged.
- R8: `close_count` increases by one on every close event, and `issued_count` increases by one on every hit accepted into the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| close_valid | input | 1 | A row is being closed this cycle |
| close_row | input | ROW_W | Address of the row being closed |
| threshold | input | 16 | Hit threshold, p = threshold/65536 |
| ref_valid | output | 1 | Refresh command offered |
| ref_cmd | output | 1 | 0 = activate, 1 = precharge |
| ref_row | output | ROW_W | Row to refresh |
| ref_ready | input | 1 | Scheduler accepts the offered command |
| close_count | output | CNT_W | Close events seen |
| issued_count | output | CNT_W | Refreshes queued |
| drop_count | output | DROP_W | Hits dropped while busy, saturating |

## Verification
The bench sweeps every row of a 16-row configuration with a threshold that almost always hits, and predicts each neighbour from its own side model. This exposes a design that swaps the alternation order, flips the side on an edge row, or wraps row 0 around to the top row. A back-pressure phase piles hits onto a pending request to catch a design that overwrites the queued row, toggles the side on a dropped hit, or lets the drop counter wrap instead of saturating. Long runs at a threshold of zero and at 328 compare the number of refreshes with an arithmetic model of the random source. An off-by-one LFSR step or a compare with the wrong sense shows up there as a count mismatch.

// File: rtl/para_pkg.sv
package para_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_PRE  = 2'd2
    } ref_state_t;

    typedef enum logic {
        CMD_ACT = 1'b0,
        CMD_PRE = 1'b1
    } ref_cmd_t;
endpackage

// File: rtl/para_lfsr.sv
module para_lfsr
    import para_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] q;
    logic              fb;

    always_comb fb = ^(q & LFSR_TAPS);

    always_ff @(posedge clk) begin
        if (rst)       q <= SEED;
        else if (step) q <= {q[LFSR_W-2:0], fb};
    end

    assign value = q;

    // R2: a maximal-length register never reaches the all-zero lock-up state
    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst) q != '0);
    // R2: the value only moves on a close event
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(q));
endmodule

// File: rtl/para_neighbour.sv
module para_neighbour #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] row,
    input  logic             commit,
    output logic [ROW_W-1:0] nbr
);
    localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

    logic side_up;
    logic at_low;
    logic at_high;

    always_comb begin
        at_low  = (row == '0);
        at_high = (row == ROW_MAX);
        if (at_low)       nbr = row + 1'b1;
        else if (at_high) nbr = row - 1'b1;
        else if (side_up) nbr = row + 1'b1;
        else              nbr = row - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                                side_up <= 1'b0;
        else if (commit && !at_low && !at_high) side_up <= ~side_up;
    end

    // R6: an edge row never moves the alternation side
    a_r6_edge_keeps_side: assert property (@(posedge clk) disable iff (rst)
        (commit && (at_low || at_high)) |=> $stable(side_up));
    // R5: an interior commit always flips the side
    a_r5_interior_flips: assert property (@(posedge clk) disable iff (rst)
        (commit && !at_low && !at_high) |=> (side_up != $past(side_up)));
endmodule

// File: rtl/para_stats.sv
module para_stats #(
    parameter int CNT_W  = 32,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_inc,
    input  logic              issue_inc,
    input  logic              drop_inc,
    output logic [CNT_W-1:0]  close_count,
    output logic [CNT_W-1:0]  issued_count,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            close_count  <= '0;
            issued_count <= '0;
            drop_count   <= '0;
        end else begin
            if (close_inc) close_count  <= close_count + 1'b1;
            if (issue_inc) issued_count <= issued_count + 1'b1;
            if (drop_inc && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
        end
    end

    a_r8_close_count: assert property (@(posedge clk) disable iff (rst)
        close_inc |=> close_count == CNT_W'($past(close_count) + 1'b1));
    a_r7_drop_saturates: assert property (@(posedge clk) disable iff (rst)
        (drop_count == DROP_MAX) |=> (drop_count == DROP_MAX));
    a_r7_drop_count: assert property (@(posedge clk) disable iff (rst)
        (drop_inc && drop_count != DROP_MAX) |=>
            drop_count == DROP_W'($past(drop_count) + 1'b1));
endmodule

// File: rtl/para_refresh_unit.sv
module para_refresh_unit
    import para_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int CNT_W  = 32,
    parameter int DROP_W = 8,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_valid,
    input  logic [ROW_W-1:0]  close_row,
    input  logic [15:0]       threshold,
    output logic              ref_valid,
    output logic              ref_cmd,
    output logic [ROW_W-1:0]  ref_row,
    input  logic              ref_ready,
    output logic [CNT_W-1:0]  close_count,
    output logic [CNT_W-1:0]  issued_count,
    output logic [DROP_W-1:0] drop_count
);
    ref_state_t        state, state_nx;
    logic [LFSR_W-1:0] draw;
    logic              hit, hit_take, hit_drop;
    logic [ROW_W-1:0]  nbr_row;
    logic [ROW_W-1:0]  row_q;

    para_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .step(close_valid), .value(draw)
    );

    always_comb begin
        hit      = close_valid && (draw < threshold);
        hit_take = hit && (state == ST_IDLE);
        hit_drop = hit && (state != ST_IDLE);
    end

    para_neighbour #(.ROW_W(ROW_W)) u_nbr (
        .clk(clk), .rst(rst), .row(close_row), .commit(hit_take), .nbr(nbr_row)
    );

    para_stats #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_stats (
        .clk(clk), .rst(rst),
        .close_inc(close_valid), .issue_inc(hit_take), .drop_inc(hit_drop),
        .close_count(close_count), .issued_count(issued_count), .drop_count(drop_count)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (hit_take)  state_nx = ST_ACT;
            ST_ACT:  if (ref_ready) state_nx = ST_PRE;
            ST_PRE:  if (ref_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row_q <= '0;
        end else begin
            state <= state_nx;
            if (hit_take) row_q <= nbr_row;
        end
    end

    always_comb begin
        ref_valid = 1'b0;
        ref_cmd   = CMD_ACT;
        unique case (state)
            ST_IDLE: ref_valid = 1'b0;
            ST_ACT:  begin ref_valid = 1'b1; ref_cmd = CMD_ACT; end
            ST_PRE:  begin ref_valid = 1'b1; ref_cmd = CMD_PRE; end
            default: ref_valid = 1'b0;
        endcase
        ref_row = row_q;
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_cmd) && $stable(ref_row)));
    a_r4_act_then_pre: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_ready && ref_cmd == CMD_ACT) |=>
            (ref_valid && ref_cmd == CMD_PRE && $stable(ref_row)));
    a_r4_pre_ends: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_ready && ref_cmd == CMD_PRE && !hit_take) |=> !ref_valid);
    a_r4_take_offers_act: assert property (@(posedge clk) disable iff (rst)
        hit_take |=> (ref_valid && ref_cmd == CMD_ACT));
    a_r6_row_zero: assert property (@(posedge clk) disable iff (rst)
        (hit_take && close_row == '0) |=> (ref_row == ROW_W'(1)));
    a_r7_drop_keeps_row: assert property (@(posedge clk) disable iff (rst)
        (hit_drop && !ref_ready) |=> $stable(ref_row));
endmodule

// File: tb/sim_para_refresh_unit.sv
module sim_para_refresh_unit;
    localparam int ROW_W  = 4;
    localparam int CNT_W  = 16;
    localparam int DROP_W = 3;
    localparam logic [ROW_W-1:0] RMAX = {ROW_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              close_valid = 1'b0;
    logic [ROW_W-1:0]  close_row = '0;
    logic [15:0]       threshold = '0;
    logic              ref_valid, ref_cmd, ref_ready = 1'b0;
    logic [ROW_W-1:0]  ref_row;
    logic [CNT_W-1:0]  close_count, issued_count;
    logic [DROP_W-1:0] drop_count;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_lfsr = 16'hACE1;
    logic        m_up = 1'b0;
    int          m_close = 0, m_issued = 0, m_drop = 0;
    logic        last_hit;

    always #10 clk = ~clk;

    para_refresh_unit #(.ROW_W(ROW_W), .CNT_W(CNT_W), .DROP_W(DROP_W)) u0 (
        .clk(clk), .rst(rst), .close_valid(close_valid), .close_row(close_row),
        .threshold(threshold), .ref_valid(ref_valid), .ref_cmd(ref_cmd),
        .ref_row(ref_row), .ref_ready(ref_ready), .close_count(close_count),
        .issued_count(issued_count), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ROW_W-1:0] pick(input logic [ROW_W-1:0] r, input bit commit);
        logic [ROW_W-1:0] n;
        if (r == 0) n = 1;
        else if (r == RMAX) n = RMAX - 1;
        else begin
            n = m_up ? r + 1 : r - 1;
            if (commit) m_up = ~m_up;
        end
        return n;
    endfunction

    // one close event; reports whether the model predicts a hit
    task automatic do_close(input logic [ROW_W-1:0] r);
        last_hit = (m_lfsr < threshold);
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_close++;
        close_valid = 1'b1;
        close_row = r;
        @(negedge clk);
        close_valid = 1'b0;
    endtask

    task automatic serve(input logic [ROW_W-1:0] exp_row, input string req);
        chk(ref_valid === 1'b1, "R4 valid after hit", ref_valid, 1);
        chk(ref_cmd === 1'b0, "R4 activate first", ref_cmd, 0);
        chk(ref_row === exp_row, req, ref_row, exp_row);
        ref_ready = 1'b1;
        @(negedge clk);
        chk(ref_valid === 1'b1 && ref_cmd === 1'b1, "R4 precharge second", ref_cmd, 1);
        chk(ref_row === exp_row, "R4 same row for precharge", ref_row, exp_row);
        @(negedge clk);
        ref_ready = 1'b0;
        chk(ref_valid === 1'b0, "R4 idle after precharge", ref_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(ref_valid === 1'b0, "R1 ref_valid", ref_valid, 0);
        chk(close_count == 0 && issued_count == 0, "R1 counters", close_count, 0);
        chk(drop_count == 0, "R1 drop_count", drop_count, 0);

        // R3: threshold zero never refreshes
        threshold = 16'd0;
        for (int i = 0; i < 40; i++) begin
            do_close(ROW_W'(i));
            chk(ref_valid === 1'b0, "R3 no request on miss", ref_valid, 0);
        end

        // R5/R6: sweep every row twice with near-certain hits
        threshold = 16'hFFFF;
        for (int pass = 0; pass < 2; pass++) begin
            for (int r = 0; r <= int'(RMAX); r++) begin
                logic [ROW_W-1:0] e;
                do_close(ROW_W'(r));
                if (last_hit) begin
                    m_issued++;
                    e = pick(ROW_W'(r), 1'b1);
                    serve(e, (r == 0 || r == int'(RMAX)) ? "R6 edge neighbour" : "R5 alternating neighbour");
                end else begin
                    chk(ref_valid === 1'b0, "R2 miss when draw equals max", ref_valid, 0);
                end
            end
        end

        // R7: back-pressure, pile hits onto a pending request
        begin
            logic [ROW_W-1:0] e;
            do_close(ROW_W'(6));
            if (last_hit) begin
                m_issued++;
                e = pick(ROW_W'(6), 1'b1);
                for (int k = 0; k < 10; k++) begin
                    do_close(ROW_W'(9));
                    if (last_hit && m_drop < 7) m_drop++;
                    @(negedge clk);
                    chk(ref_valid === 1'b1 && ref_row === e, "R7 pending kept while busy", ref_row, e);
                end
                chk(drop_count == m_drop, "R7 drop count saturates", drop_count, m_drop);
                serve(e, "R7 queued row survives drops");
                // side must be unchanged by drops
                do_close(ROW_W'(9));
                if (last_hit) begin
                    m_issued++;
                    e = pick(ROW_W'(9), 1'b1);
                    serve(e, "R7 side unchanged by drops");
                end
            end
        end

        // R2/R8: statistical run at p = 328/65536 with ready always high
        threshold = 16'd328;
        ref_ready = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            do_close(ROW_W'(i % 13 + 1));
            if (last_hit) begin
                m_issued++;
                void'(pick(ROW_W'(i % 13 + 1), 1'b1));
            end
            repeat (2) @(negedge clk);
        end
        ref_ready = 1'b0;
        chk(issued_count == CNT_W'(m_issued), "R2 hit count matches model", issued_count, m_issued);
        chk(issued_count == CNT_W'(m_issued), "R8 issued_count", issued_count, m_issued);
        chk(close_count == CNT_W'(m_close), "R8 close_count", close_count, m_close);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule